// File: doc/BRIEF.md
# SPI Serial Flash Host Controller

This block is the host side of a serial flash link. A requester hands it either a read job (start address plus byte count) or a single-byte program job (address plus data). The controller turns each job into the serial frames the flash device expects. It drives the serial clock, chip select and data-out lines in SPI mode 0, and it gathers the bytes that come back on the data-in line.

A read is one chip-select frame. The frame holds the fast-read opcode 0x0B, a 24-bit address, one dummy byte and then as many data bytes as were asked for. The data bytes go to the requester on a valid/ready stream. The controller never adjusts the address itself, so a read that runs past the top of the flash address space continues from the bottom. A program job takes several frames, each framed by chip select on its own:
- first a write-enable frame,
- then the program frame,
- then status-read frames, repeated until the busy flag clears or a poll limit is reached.

The sequencer moves through these named states:
- S_IDLE, waiting for a job;
- S_WREN, S_PROG and S_POLL, shifting the bytes of the write-enable, program and status frames;
- S_RHDR, shifting the read header;
- S_RDAT, receiving one data byte;
- S_RPUSH, offering that byte to the requester;
- S_GAP, holding chip select high between frames.

Transitions:
- S_IDLE goes to S_WREN on a program job and to S_RHDR on a read job with a non-zero count. A zero-count read stays in S_IDLE.
- S_WREN goes to S_GAP, and that gap leads to S_PROG.
- S_PROG goes to S_GAP, and that gap leads to S_POLL.
- S_POLL goes to S_GAP. That gap leads back to S_POLL while the flash is busy and the limit has not been reached. It leads to S_IDLE when the flash is ready (finish) or when the limit is reached (fail).
- S_RHDR goes to S_RDAT.
- S_RDAT goes to S_RPUSH.
- S_RPUSH goes back to S_RDAT while bytes remain. After the last byte it goes to S_GAP, and that gap leads to S_IDLE.

Top module: `sflash_host`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, req_ready is 1, and rd_valid, done and err are 0.
- R2: A read job with a non-zero count opens one chip-select frame. The frame carries 0x0B, then the address bits 23 down to 0, then one dummy byte, all MSB first. No data byte is delivered before the dummy byte has been shifted.
- R3: A read job with count N delivers exactly N bytes on rd_data, taken from consecutive flash addresses starting at the given one. The frame holds exactly 5+N bytes, and spi_cs_n rises after the last one. When the read runs past address 0xFFFFFF, the frame stays open and the stream continues from 0x000000.
- R4: While rd_valid is 1 and rd_ready is 0, rd_valid stays 1, rd_data stays stable and spi_sck does not toggle.
- R5: A program job first sends a frame holding only 0x06. It then sends a separate frame of exactly five bytes: 0x02, the 24-bit address and the data byte, MSB first.
- R6: After the program frame, the controller sends status frames of two bytes each: 0x05 and one byte clocked in. Bit 0 of the incoming byte is the busy flag. Status frames repeat while it reads 1, and the job finishes after the first status frame that reads 0.
- R7: If POLL_LIMIT consecutive status frames all read busy, the job ends with err, and no further frame is sent.
- R8: Each accepted job produces exactly one single-cycle pulse on done. err is 1 only in the cycle of a done that ends a job on timeout.
- R9: req_ready is 1 only while the controller is idle. It is never 1 while spi_cs_n is low, and it drops in the cycle after a job that opens a frame is accepted.
- R10: Between two frames, spi_cs_n stays high for at least 2*DIV clock cycles.
- R11: SPI mode 0. spi_sck is 0 whenever spi_cs_n changes. spi_mosi changes only on a falling spi_sck edge or while spi_sck is low. spi_miso is sampled on the rising edge.
- R12: A read job with count 0 produces a done pulse and no chip-select activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Job request valid |
| req_ready | output | 1 | Controller idle, able to take a job |
| req_write | input | 1 | 1 = byte program, 0 = read |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Read byte count |
| req_wdata | input | 8 | Byte to program |
| rd_valid | output | 1 | Read data byte valid |
| rd_ready | input | 1 | Requester takes read byte |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | One-cycle job completion pulse |
| err | output | 1 | Job ended on poll timeout (with done) |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The states that are hardest to reach from the ports are the poll timeout and a stalled data stream in the middle of a frame. Both depend on what the flash and the requester do, not on the controller. The bench therefore includes a behavioural flash. Before each job, the bench loads this model with the number of status reads that will report busy; a very large value forces the timeout path. The model also answers reads from any 24-bit address, so a read that starts just below 0xFFFFFF can be checked for wrap-around. A throttled rd_ready pattern holds bytes in S_RPUSH while the frame is still open.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_FREAD = 8'h0B;
    localparam logic [7:0] FILLER   = 8'h00;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WREN,
        S_PROG,
        S_POLL,
        S_RHDR,
        S_RDAT,
        S_RPUSH,
        S_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        G_TO_PROG,
        G_TO_POLL,
        G_TO_FINISH,
        G_TO_FAIL
    } gap_next_t;

endpackage

// File: rtl/sflash_byte_shift.sv
module sflash_byte_shift #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    sh_tx;
    logic [7:0]    sh_rx;
    logic          sck_q;
    logic          mosi_q;
    logic          active;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_idx <= '0;
            sh_tx   <= '0;
            sh_rx   <= '0;
            sck_q   <= 1'b0;
            mosi_q  <= 1'b0;
            active  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                mosi_q  <= tx_byte[7];
                sh_tx   <= {tx_byte[6:0], 1'b0};
                bit_idx <= '0;
                div_cnt <= '0;
                sck_q   <= 1'b0;
            end else if (active) begin
                if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        sh_rx <= {sh_rx[6:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            mosi_q  <= sh_tx[7];
                            sh_tx   <= {sh_tx[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = mosi_q;
    assign done    = done_q;
    assign rx_byte = sh_rx;

    // Mode 0: data out holds while the clock is high (R11)
    assert_mosi_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi_q));

endmodule

// File: rtl/sflash_poll_guard.sv
module sflash_poll_guard #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic final_poll
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign final_poll = (cnt == W'(LIMIT - 1));

    // The sequencer never polls past the limit (R7)
    assert_poll_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt < W'(LIMIT)));

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
    import sflash_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       req_wdata,
    output logic             req_ready,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err,
    output logic             eng_start,
    output logic [7:0]       eng_tx,
    input  logic             eng_done,
    input  logic [7:0]       eng_rx,
    output logic             cs_n,
    output logic             poll_clear,
    output logic             poll_tick,
    input  logic             poll_final
);
    localparam int GAP_CYC = 2 * DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
    localparam logic [2:0] HDR_LAST  = 3'd4;
    localparam logic [2:0] PROG_LAST = 3'd4;

    seq_state_t       state;
    gap_next_t        gnext;
    logic [2:0]       idx;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       wdata_q;
    logic [7:0]       rdat_q;
    logic [GW-1:0]    gap_cnt;
    logic             kick;
    logic             done_q;
    logic             err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            gnext   <= G_TO_FINISH;
            idx     <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            wdata_q <= '0;
            rdat_q  <= '0;
            gap_cnt <= '0;
            kick    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            kick   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        len_q   <= req_len;
                        wdata_q <= req_wdata;
                        idx     <= '0;
                        if (req_write) begin
                            state <= S_WREN;
                            kick  <= 1'b1;
                        end else if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state <= S_RHDR;
                            kick  <= 1'b1;
                        end
                    end
                end
                S_WREN: begin
                    if (eng_done) begin
                        state   <= S_GAP;
                        gnext   <= G_TO_PROG;
                        gap_cnt <= '0;
                    end
                end
                S_PROG: begin
                    if (eng_done) begin
                        if (idx == PROG_LAST) begin
                            state   <= S_GAP;
                            gnext   <= G_TO_POLL;
                            gap_cnt <= '0;
                        end else begin
                            idx  <= idx + 3'd1;
                            kick <= 1'b1;
                        end
                    end
                end
                S_POLL: begin
                    if (eng_done) begin
                        if (idx == 3'd0) begin
                            idx  <= 3'd1;
                            kick <= 1'b1;
                        end else begin
                            state   <= S_GAP;
                            gap_cnt <= '0;
                            if (!eng_rx[0]) begin
                                gnext <= G_TO_FINISH;
                            end else if (poll_final) begin
                                gnext <= G_TO_FAIL;
                            end else begin
                                gnext <= G_TO_POLL;
                            end
                        end
                    end
                end
                S_RHDR: begin
                    if (eng_done) begin
                        if (idx == HDR_LAST) begin
                            state <= S_RDAT;
                        end else begin
                            idx <= idx + 3'd1;
                        end
                        kick <= 1'b1;
                    end
                end
                S_RDAT: begin
                    if (eng_done) begin
                        rdat_q <= eng_rx;
                        state  <= S_RPUSH;
                    end
                end
                S_RPUSH: begin
                    if (rd_ready) begin
                        if (len_q == LEN_W'(1)) begin
                            state   <= S_GAP;
                            gnext   <= G_TO_FINISH;
                            gap_cnt <= '0;
                        end else begin
                            len_q <= len_q - 1'b1;
                            state <= S_RDAT;
                            kick  <= 1'b1;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_cnt == GAP_LAST) begin
                        idx <= '0;
                        unique case (gnext)
                            G_TO_PROG: begin
                                state <= S_PROG;
                                kick  <= 1'b1;
                            end
                            G_TO_POLL: begin
                                state <= S_POLL;
                                kick  <= 1'b1;
                            end
                            G_TO_FINISH: begin
                                state  <= S_IDLE;
                                done_q <= 1'b1;
                            end
                            G_TO_FAIL: begin
                                state  <= S_IDLE;
                                done_q <= 1'b1;
                                err_q  <= 1'b1;
                            end
                            default: state <= S_IDLE;
                        endcase
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        eng_tx     = FILLER;
        cs_n       = 1'b0;
        req_ready  = 1'b0;
        rd_valid   = 1'b0;
        poll_tick  = 1'b0;
        poll_clear = 1'b0;
        unique case (state)
            S_IDLE: begin
                cs_n       = 1'b1;
                req_ready  = 1'b1;
                poll_clear = req_valid;
            end
            S_WREN: eng_tx = OP_WREN;
            S_PROG: begin
                unique case (idx)
                    3'd0:    eng_tx = OP_PROG;
                    3'd1:    eng_tx = addr_q[23:16];
                    3'd2:    eng_tx = addr_q[15:8];
                    3'd3:    eng_tx = addr_q[7:0];
                    default: eng_tx = wdata_q;
                endcase
            end
            S_POLL: begin
                eng_tx    = (idx == 3'd0) ? OP_RDSR : FILLER;
                poll_tick = eng_done && (idx != 3'd0);
            end
            S_RHDR: begin
                unique case (idx)
                    3'd0:    eng_tx = OP_FREAD;
                    3'd1:    eng_tx = addr_q[23:16];
                    3'd2:    eng_tx = addr_q[15:8];
                    3'd3:    eng_tx = addr_q[7:0];
                    default: eng_tx = FILLER;
                endcase
            end
            S_RDAT:  eng_tx = FILLER;
            S_RPUSH: rd_valid = 1'b1;
            S_GAP:   cs_n = 1'b1;
            default: cs_n = 1'b1;
        endcase
    end

    assign eng_start = kick;
    assign rd_data   = rdat_q;
    assign done      = done_q;
    assign err       = err_q;

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_leave_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_write || (req_len != '0))) |=> !req_ready);

    assert_gap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);

endmodule

// File: rtl/sflash_host.sv
module sflash_host #(
    parameter int LEN_W      = 16,
    parameter int DIV        = 4,
    parameter int POLL_LIMIT = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       req_wdata,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             err,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;
    logic       poll_clear;
    logic       poll_tick;
    logic       poll_final;

    sflash_seq #(
        .LEN_W (LEN_W),
        .DIV   (DIV)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data),
        .done       (done),
        .err        (err),
        .eng_start  (eng_start),
        .eng_tx     (eng_tx),
        .eng_done   (eng_done),
        .eng_rx     (eng_rx),
        .cs_n       (spi_cs_n),
        .poll_clear (poll_clear),
        .poll_tick  (poll_tick),
        .poll_final (poll_final)
    );

    sflash_byte_shift #(
        .DIV (DIV)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    sflash_poll_guard #(
        .LIMIT (POLL_LIMIT)
    ) guard_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (poll_clear),
        .tick       (poll_tick),
        .final_poll (poll_final)
    );

    // Chip select only moves while the serial clock rests low (R11)
    assert_cs_edge_sck_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> !spi_sck);

    // No job accepted while a frame is open (R9)
    assert_ready_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !req_ready);

endmodule

// File: tb/sflash_host_tb_top.sv
`timescale 1ns/1ps
module sflash_host_tb_top;

    localparam int DIV   = 2;
    localparam int LIMIT = 8;

    typedef struct packed {
        logic        wr;
        logic [23:0] addr;
        logic [15:0] len;
        logic [7:0]  wdata;
        logic [7:0]  polls;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h000100, 16'd4, 8'h00, 8'd0},
        '{1'b1, 24'h012345, 16'd0, 8'h3C, 8'd0},
        '{1'b0, 24'hFFFFFE, 16'd5, 8'h00, 8'd0},
        '{1'b1, 24'hABCDEF, 16'd0, 8'hC3, 8'd3},
        '{1'b0, 24'h00FF00, 16'd1, 8'h00, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        done;
    logic        err;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        miso_m = 1'b0;

    always #2 clk = ~clk;

    sflash_host #(
        .LEN_W      (16),
        .DIV        (DIV),
        .POLL_LIMIT (LIMIT)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .req_wdata (req_wdata),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .done      (done),
        .err       (err),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (miso_m)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_at(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
    endfunction

    // Behavioural flash
    int          nbits, nbytes, busy_left, nframes;
    bit          in_frame = 1'b0;
    logic [7:0]  sin, op, obyte, pdata;
    logic [23:0] hdr, maddr;
    logic [7:0]  f_op   [64];
    int          f_len  [64];
    logic [23:0] f_addr [64];
    logic [7:0]  f_data [64];

    always @(negedge spi_cs_n) begin
        in_frame = 1'b1;
        nbits = 0; nbytes = 0; op = 8'h00; hdr = '0; pdata = 8'h00;
    end

    always @(posedge spi_cs_n) begin
        if (in_frame && nframes < 64) begin
            f_op[nframes] = op; f_len[nframes] = nbytes;
            f_addr[nframes] = hdr; f_data[nframes] = pdata;
            nframes++;
        end
        in_frame = 1'b0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sin = {sin[6:0], spi_mosi};
            nbits++;
            if (nbits == 8) begin
                nbits = 0;
                if (nbytes == 0) op = sin;
                else if (nbytes <= 3) begin
                    hdr = {hdr[15:0], sin};
                    if (nbytes == 3) maddr = hdr;
                end else if (nbytes == 4) pdata = sin;
                nbytes++;
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (nbits == 0) begin
                if (op == 8'h05 && nbytes == 1) begin
                    obyte = {7'b0, (busy_left > 0)};
                    if (busy_left > 0) busy_left--;
                end else if (op == 8'h0B && nbytes >= 5) begin
                    obyte = mem_at(maddr);
                    maddr = maddr + 24'd1;
                end else begin
                    obyte = 8'h00;
                end
            end
            miso_m = obyte[7 - nbits];
        end
    end

    // Port monitors
    logic [7:0] cap [64];
    int ncap, ndone, ready_viol, hold_viol, cs_sck_viol, gap_run;
    int min_gap = 1000000;
    bit last_err, prev_hold, prev_sck, prev_cs = 1'b1, seen_frame;
    logic [7:0] prev_data;
    bit bp = 1'b0;
    int cyc = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (rd_valid && rd_ready && ncap < 64) begin cap[ncap] = rd_data; ncap++; end
            if (done) begin ndone++; last_err = err; end
            if (!spi_cs_n && req_ready) ready_viol++;
            if (prev_hold && !(rd_valid && rd_data == prev_data && spi_sck == prev_sck)) hold_viol++;
            prev_hold = rd_valid && !rd_ready;
            prev_data = rd_data;
            prev_sck  = spi_sck;
            if (spi_cs_n != prev_cs && spi_sck) cs_sck_viol++;
            prev_cs = spi_cs_n;
            if (spi_cs_n) gap_run++;
            else begin
                if (gap_run > 0 && seen_frame && gap_run < min_gap) min_gap = gap_run;
                gap_run = 0;
                seen_frame = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        rd_ready = bp ? (cyc % 3 == 2) : 1'b1;
    end

    task automatic run(bit wr, logic [23:0] a, int len, logic [7:0] d, int polls);
        nframes = 0; ncap = 0; ndone = 0; last_err = 1'b0; busy_left = polls;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_len = 16'(len); req_wdata = d;
        do @(posedge clk); while (!req_ready);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 20000 && ndone == 0; i++) @(posedge clk);
        if (ndone == 0) begin
            checks++; fails++;
            $display("FAIL R8 job timeout actual=0 expected=1");
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic check_read(logic [23:0] a, int len, string tag);
        chk("R2", {tag, " frames"}, nframes, 1);
        chk("R2", {tag, " opcode"}, f_op[0], 8'h0B);
        chk("R2", {tag, " address"}, f_addr[0], a);
        chk("R3", {tag, " frame bytes"}, f_len[0], 5 + len);
        chk("R3", {tag, " byte count"}, ncap, len);
        for (int i = 0; i < len && i < 64; i++)
            chk("R3", {tag, " data"}, cap[i], mem_at(a + 24'(i)));
        chk("R8", {tag, " done"}, ndone, 1);
        chk("R8", {tag, " err"}, last_err, 0);
    endtask

    task automatic check_prog(logic [23:0] a, logic [7:0] d, int polls, string tag);
        int bad = 0;
        chk("R6", {tag, " frames"}, nframes, polls + 3);
        chk("R5", {tag, " wren op"}, f_op[0], 8'h06);
        chk("R5", {tag, " wren len"}, f_len[0], 1);
        chk("R5", {tag, " prog op"}, f_op[1], 8'h02);
        chk("R5", {tag, " prog len"}, f_len[1], 5);
        chk("R5", {tag, " prog addr"}, f_addr[1], a);
        chk("R5", {tag, " prog data"}, f_data[1], d);
        for (int i = 2; i < nframes && i < 64; i++)
            if (f_op[i] != 8'h05 || f_len[i] != 2) bad++;
        chk("R6", {tag, " status frames malformed"}, bad, 0);
        chk("R8", {tag, " done"}, ndone, 1);
        chk("R8", {tag, " err"}, last_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cs_n", spi_cs_n, 1);
        chk("R1", "sck", spi_sck, 0);
        chk("R1", "req_ready", req_ready, 1);
        chk("R1", "rd_valid", rd_valid, 0);
        chk("R1", "done|err", done | err, 0);

        for (int v = 0; v < NV; v++) begin
            run(VECS[v].wr, VECS[v].addr, int'(VECS[v].len), VECS[v].wdata, int'(VECS[v].polls));
            if (VECS[v].wr) check_prog(VECS[v].addr, VECS[v].wdata, int'(VECS[v].polls), "vec");
            else check_read(VECS[v].addr, int'(VECS[v].len), "vec");
        end

        // R12: zero-length read
        run(1'b0, 24'h000040, 0, 8'h00, 0);
        chk("R12", "zero-len frames", nframes, 0);
        chk("R12", "zero-len done", ndone, 1);

        // R7: flash stays busy past the poll limit
        run(1'b1, 24'h000777, 0, 8'h55, 200);
        chk("R7", "timeout frames", nframes, 2 + LIMIT);
        chk("R7", "timeout err", last_err, 1);
        chk("R8", "timeout done", ndone, 1);

        // R4: throttled consumer in the middle of a frame
        bp = 1'b1;
        run(1'b0, 24'h000200, 6, 8'h00, 0);
        bp = 1'b0;
        check_read(24'h000200, 6, "bp");
        chk("R4", "hold violations", hold_viol, 0);

        chk("R9", "ready while frame open", ready_viol, 0);
        chk("R10", "min cs high gap ok", (min_gap >= 2 * DIV) ? 1 : 0, 1);
        chk("R11", "cs moved with sck high", cs_sck_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule